// File: doc/BRIEF.md
# Flash Access Protection Checker

This block stands in the request path between a system bus and an on-chip flash array. For every read, program or page-erase request it decides whether the operation may proceed. It combines two protection mechanisms. The first is a per-region write guard built from a 32-bit protection field. The second is a device security level derived from a 16-bit security word, which is a security byte together with its complement. It also follows the live debug and boot-source state. Its outputs are a grant or deny verdict, a bus-error pulse for refused reads, a sticky write-protect error flag with a gated interrupt, and a mass-erase strobe.

The protection field and the security word come from option storage outside the block. They are captured only once after every system reset, so edits take effect at the next reset. A second reset input marks power-on. A register held in that domain remembers the security level of the previous configuration. This lets the block request a full main-flash mass erase when a reset moves the device from protected back to unprotected. Main flash spans 128 KB split into 32 regions of 4 KB each. The region of a request is given by address bits [16:12].

Top module: `flash_guard`

## Requirements
- R1: A program (req_op_i = 2'b01) or page erase (req_op_i = 2'b10) to main flash (req_obyte_i = 0) whose region bit, indexed by req_addr_i[16:12] in the captured protection field, is 0 is denied and sets the error flag. A region whose bit is 1 is granted when no other rule refuses it.
- R2: The write-protect error flag is sticky. It is cleared only by wperr_clr_i = 1. When a refusal and a clear occur in the same cycle, the flag ends up set.
- R3: err_irq_o is high exactly when the error flag is set and err_ie_i is 1.
- R4: A page erase of the option-byte block (req_obyte_i = 1, req_op_i = 2'b10) lifts all region write protection for later requests, until the next system reset.
- R5: A captured security word equal to 16'h5AA5 means unprotected. In that level, main-flash reads are granted in every mode, and program or erase is refused only by region bits. Any other word means protected.
- R6: When protected, program or erase anywhere in region 0 (addresses below 4 KB) is denied and sets the error flag in every mode.
- R7: When protected and in a non-user mode (dbg_mode_i = 1, or boot_sel_i not 2'b00, where 2'b01 = boot from SRAM and 2'b10 = boot from loader), the rules are as follows. A main-flash read is denied with a bus_err_o pulse and leaves the flag unchanged. A program or erase is denied and sets the flag. Reads in user mode are granted.
- R8: Every read, program or erase to the option-byte block is granted at any level, in any mode and with any region bits.
- R9: The protection field and security word are captured on the first clock after the system reset is released. Later changes at opt_wp_i and opt_sec_i have no effect until the next reset. Requests made before capture are denied without error.
- R10: mass_erase_o pulses for exactly one cycle at capture, and only when the previously captured level was protected and the new level is unprotected. No pulse is issued on the first capture after power-on.
- R11: A request with req_valid_i produces, in the next cycle, exactly one of grant_o and deny_o. The reserved operation 2'b11 is denied without a bus error and without touching the flag. bus_err_o appears only on refused reads.
- R12: While reset is held, grant_o, deny_o, bus_err_o, wperr_o, err_irq_o and mass_erase_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset, keeps the previous level |
| opt_wp_i | input | 32 | Region protection field, bit 0 = protected |
| opt_sec_i | input | 16 | Security byte with its complement |
| dbg_mode_i | input | 1 | Debug probe attached |
| boot_sel_i | input | 2 | Boot source: 00 user flash, 01 SRAM, 10 loader |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 00 read, 01 program, 10 page erase, 11 reserved |
| req_obyte_i | input | 1 | Request targets the option-byte block |
| req_addr_i | input | 17 | Main-flash byte address |
| err_ie_i | input | 1 | Error interrupt enable |
| wperr_clr_i | input | 1 | Clear the error flag (write 1) |
| grant_o | output | 1 | Request allowed (one cycle after request) |
| deny_o | output | 1 | Request refused (one cycle after request) |
| bus_err_o | output | 1 | Bus error response for a refused read |
| wperr_o | output | 1 | Sticky write-protect error flag |
| err_irq_o | output | 1 | Error interrupt |
| mass_erase_o | output | 1 | Single-cycle main-flash mass-erase request |

## Verification
The bench builds the block with its default widths: a 17-bit address and 4 KB regions, which gives 32 region bits with region 0 as the locked boot area. These values put the 4 KB boundary, regions inside and outside a partly cleared protection field, and the whole field within reach using a handful of addresses. A scoreboard predicts every verdict and the flag value after it from a model of the captured configuration. It runs a chain of resets that covers first power-up, the protected-to-unprotected transition and the unchanged-level cases, and counts mass-erase pulses around each capture.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RSVD  = 2'b11
  } fg_op_e;

  typedef enum logic [1:0] {
    BOOT_USER   = 2'b00,
    BOOT_SRAM   = 2'b01,
    BOOT_LOADER = 2'b10,
    BOOT_RSVD   = 2'b11
  } fg_boot_e;

  typedef struct packed {
    logic grant;
    logic deny;
    logic bus_err;
    logic wp_err;
  } fg_verdict_t;

endpackage

// File: rtl/fg_rst_sync.sv
`timescale 1ns/1ps
module fg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/fg_cfg.sv
`timescale 1ns/1ps
module fg_cfg #(
  parameter int          WP_W   = 32,
  parameter int          SEC_W  = 16,
  parameter logic [15:0] UNLOCK = 16'h5AA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic [WP_W-1:0]  opt_wp_i,
  input  logic [SEC_W-1:0] opt_sec_i,
  input  logic             obyte_erase_i,
  output logic             cfg_vld_o,
  output logic [WP_W-1:0]  wp_eff_o,
  output logic             locked_o,
  output logic             mass_erase_o
);

  localparam logic [SEC_W-1:0] UNLOCK_W = SEC_W'(UNLOCK);

  // system-reset domain
  logic            vld_q, vld_d;
  logic [WP_W-1:0] wp_q, wp_d;
  logic            locked_q, locked_d;
  logic            wp_off_q, wp_off_d;
  logic            me_q, me_d;
  // power-on domain: level seen before the latest system reset
  logic            prev_locked_q, prev_locked_d;
  logic            seen_q, seen_d;

  logic load;
  logic new_locked;

  always_comb begin
    load          = rst_n && !vld_q;
    new_locked    = (opt_sec_i != UNLOCK_W);
    vld_d         = vld_q | load;
    wp_d          = load ? opt_wp_i : wp_q;
    locked_d      = load ? new_locked : locked_q;
    wp_off_d      = load ? 1'b0 : (wp_off_q | obyte_erase_i);
    me_d          = load && seen_q && prev_locked_q && !new_locked;
    seen_d        = seen_q | load;
    prev_locked_d = load ? new_locked : prev_locked_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      wp_q     <= '0;
      locked_q <= 1'b1;
      wp_off_q <= 1'b0;
      me_q     <= 1'b0;
    end else begin
      vld_q    <= vld_d;
      wp_q     <= wp_d;
      locked_q <= locked_d;
      wp_off_q <= wp_off_d;
      me_q     <= me_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prev_locked_q <= 1'b0;
      seen_q        <= 1'b0;
    end else begin
      prev_locked_q <= prev_locked_d;
      seen_q        <= seen_d;
    end
  end

  assign cfg_vld_o    = vld_q;
  assign wp_eff_o     = wp_q | {WP_W{wp_off_q}};
  assign locked_o     = locked_q;
  assign mass_erase_o = me_q;

  AST_ME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_o |=> !mass_erase_o); // R10
  AST_ME_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase_o |-> (vld_q && !locked_q)); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(vld_q)) |-> ($stable(wp_q) && $stable(locked_q))); // R9
  AST_WPOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wp_off_q |=> wp_off_q); // R4

endmodule

// File: rtl/fg_decide.sv
`timescale 1ns/1ps
module fg_decide
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 12,
  parameter int BOOT_LOCK = 1,
  localparam int REG_W    = ADDR_W - PAGE_BITS,
  localparam int WP_W     = 1 << REG_W
) (
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic              req_obyte_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              dbg_mode_i,
  input  logic [1:0]        boot_sel_i,
  input  logic              cfg_vld_i,
  input  logic [WP_W-1:0]   wp_eff_i,
  input  logic              locked_i,
  output fg_verdict_t       verdict_o,
  output logic              obyte_erase_o
);

  fg_op_e           op;
  logic             non_user;
  logic [REG_W-1:0] region;
  logic [WP_W-1:0]  region_blk;
  logic             hit_blk;

  assign op       = fg_op_e'(req_op_i);
  assign region   = req_addr_i[ADDR_W-1:PAGE_BITS];
  assign non_user = dbg_mode_i || (fg_boot_e'(boot_sel_i) != BOOT_USER);

  // per-region write block: region bit cleared, or boot area while protected
  for (genvar i = 0; i < WP_W; i++) begin : g_region
    if (i < BOOT_LOCK) begin : g_boot
      assign region_blk[i] = !wp_eff_i[i] || locked_i;
    end else begin : g_plain
      assign region_blk[i] = !wp_eff_i[i];
    end
  end

  assign hit_blk = region_blk[region];

  always_comb begin
    verdict_o = '0;
    if (req_valid_i) begin
      if (!cfg_vld_i || (op == OP_RSVD)) begin
        verdict_o.deny = 1'b1;
      end else if (req_obyte_i) begin
        verdict_o.grant = 1'b1;
      end else if (op == OP_READ) begin
        if (locked_i && non_user) begin
          verdict_o.deny    = 1'b1;
          verdict_o.bus_err = 1'b1;
        end else begin
          verdict_o.grant = 1'b1;
        end
      end else begin
        if (hit_blk || (locked_i && non_user)) begin
          verdict_o.deny   = 1'b1;
          verdict_o.wp_err = 1'b1;
        end else begin
          verdict_o.grant = 1'b1;
        end
      end
    end
  end

  assign obyte_erase_o = req_valid_i && cfg_vld_i && req_obyte_i && (op == OP_ERASE);

endmodule

// File: rtl/fg_errflag.sv
`timescale 1ns/1ps
module fg_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q, flag_d;

  always_comb begin
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R2
  AST_FLAG_NOSELF: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !set_i) |=> !flag_o); // R2
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && ie_i)); // R3

endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int          ADDR_W    = 17,
  parameter int          PAGE_BITS = 12,
  parameter int          BOOT_LOCK = 1,
  parameter int          SEC_W     = 16,
  parameter logic [15:0] UNLOCK    = 16'h5AA5,
  localparam int         WP_W      = 1 << (ADDR_W - PAGE_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [WP_W-1:0]   opt_wp_i,
  input  logic [SEC_W-1:0]  opt_sec_i,
  input  logic              dbg_mode_i,
  input  logic [1:0]        boot_sel_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic              req_obyte_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              err_ie_i,
  input  logic              wperr_clr_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic              bus_err_o,
  output logic              wperr_o,
  output logic              err_irq_o,
  output logic              mass_erase_o
);

  localparam int REG_W = ADDR_W - PAGE_BITS;

  logic            rst_sn;
  logic            por_sn;
  logic            cfg_vld;
  logic [WP_W-1:0] wp_eff;
  logic            locked;
  logic            obyte_erase;
  fg_verdict_t     verdict;

  logic grant_q, grant_d;
  logic deny_q, deny_d;
  logic berr_q, berr_d;

  fg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  fg_rst_sync #(.STAGES(2)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_sn)
  );

  fg_cfg #(
    .WP_W   (WP_W),
    .SEC_W  (SEC_W),
    .UNLOCK (UNLOCK)
  ) u_cfg (
    .clk           (clk),
    .rst_n         (rst_sn),
    .por_n         (por_sn),
    .opt_wp_i      (opt_wp_i),
    .opt_sec_i     (opt_sec_i),
    .obyte_erase_i (obyte_erase),
    .cfg_vld_o     (cfg_vld),
    .wp_eff_o      (wp_eff),
    .locked_o      (locked),
    .mass_erase_o  (mass_erase_o)
  );

  fg_decide #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .BOOT_LOCK (BOOT_LOCK)
  ) u_decide (
    .req_valid_i   (req_valid_i),
    .req_op_i      (req_op_i),
    .req_obyte_i   (req_obyte_i),
    .req_addr_i    (req_addr_i),
    .dbg_mode_i    (dbg_mode_i),
    .boot_sel_i    (boot_sel_i),
    .cfg_vld_i     (cfg_vld),
    .wp_eff_i      (wp_eff),
    .locked_i      (locked),
    .verdict_o     (verdict),
    .obyte_erase_o (obyte_erase)
  );

  fg_errflag u_errflag (
    .clk    (clk),
    .rst_n  (rst_sn),
    .set_i  (verdict.wp_err),
    .clr_i  (wperr_clr_i),
    .ie_i   (err_ie_i),
    .flag_o (wperr_o),
    .irq_o  (err_irq_o)
  );

  always_comb begin
    grant_d = verdict.grant;
    deny_d  = verdict.deny;
    berr_d  = verdict.bus_err;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      deny_q  <= deny_d;
      berr_q  <= berr_d;
    end
  end

  assign grant_o   = grant_q;
  assign deny_o    = deny_q;
  assign bus_err_o = berr_q;

  logic             non_user_a;
  logic             wr_main_a;
  logic [REG_W-1:0] region_a;
  assign non_user_a = dbg_mode_i || (boot_sel_i != 2'b00);
  assign wr_main_a  = req_valid_i && cfg_vld && !req_obyte_i &&
                      ((req_op_i == 2'b01) || (req_op_i == 2'b10));
  assign region_a   = req_addr_i[ADDR_W-1:PAGE_BITS];

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_sn)
    req_valid_i |=> (grant_o ^ deny_o)); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_sn)
    !req_valid_i |=> (!grant_o && !deny_o && !bus_err_o)); // R11
  AST_BERR_READ: assert property (@(posedge clk) disable iff (!rst_sn)
    bus_err_o |-> (deny_o && ($past(req_op_i) == 2'b00))); // R7
  AST_OBYTE_OPEN: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid_i && cfg_vld && req_obyte_i && (req_op_i != 2'b11)) |=> grant_o); // R8
  AST_BOOT_LOCK: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_main_a && locked && (int'(region_a) < BOOT_LOCK)) |=> (deny_o && wperr_o)); // R6
  AST_REGION_WP: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_main_a && !wp_eff[region_a]) |=> (deny_o && wperr_o)); // R1
  AST_NONUSER_WR: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_main_a && locked && non_user_a) |=> (deny_o && wperr_o)); // R7
  AST_OPEN_READ: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid_i && cfg_vld && !req_obyte_i && (req_op_i == 2'b00) && !locked) |=> grant_o); // R5
  AST_PRECFG_DENY: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_valid_i && !cfg_vld) |=> (deny_o && !bus_err_o)); // R9

endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;

  localparam int ADDR_W    = 17;
  localparam int PAGE_BITS = 12;
  localparam int WP_W      = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, por_n;
  logic [WP_W-1:0]   opt_wp_i;
  logic [15:0]       opt_sec_i;
  logic              dbg_mode_i;
  logic [1:0]        boot_sel_i;
  logic              req_valid_i;
  logic [1:0]        req_op_i;
  logic              req_obyte_i;
  logic [ADDR_W-1:0] req_addr_i;
  logic              err_ie_i, wperr_clr_i;
  logic              grant_o, deny_o, bus_err_o, wperr_o, err_irq_o, mass_erase_o;

  flash_guard #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .BOOT_LOCK (1),
    .SEC_W     (16),
    .UNLOCK    (16'h5AA5)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .por_n (por_n),
    .opt_wp_i (opt_wp_i), .opt_sec_i (opt_sec_i),
    .dbg_mode_i (dbg_mode_i), .boot_sel_i (boot_sel_i),
    .req_valid_i (req_valid_i), .req_op_i (req_op_i),
    .req_obyte_i (req_obyte_i), .req_addr_i (req_addr_i),
    .err_ie_i (err_ie_i), .wperr_clr_i (wperr_clr_i),
    .grant_o (grant_o), .deny_o (deny_o), .bus_err_o (bus_err_o),
    .wperr_o (wperr_o), .err_irq_o (err_irq_o), .mass_erase_o (mass_erase_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int me_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (mass_erase_o) me_cnt = me_cnt + 1;

  typedef struct packed { logic g; logic d; logic b; logic f; } vrd_t;
  typedef struct { vrd_t v; logic flag; string tag; int due; } item_t;
  item_t sb[$];

  // bench model of the captured configuration
  logic [WP_W-1:0] m_wp;
  logic [15:0]     m_sec;
  bit              m_wpoff;
  bit              m_flag;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic vrd_t model(logic [1:0] op, logic obyte, logic [ADDR_W-1:0] addr);
    vrd_t v = '0;
    bit locked  = (m_sec != 16'h5AA5);
    bit nonuser = dbg_mode_i || (boot_sel_i != 2'b00);
    int reg_i   = int'(addr[ADDR_W-1:PAGE_BITS]);
    if (op == 2'b11) v.d = 1;
    else if (obyte) v.g = 1;
    else if (op == 2'b00) begin
      if (locked && nonuser) begin v.d = 1; v.b = 1; end
      else v.g = 1;
    end else begin
      if ((!m_wpoff && !m_wp[reg_i]) || (locked && (nonuser || reg_i == 0))) begin
        v.d = 1; v.f = 1;
      end else v.g = 1;
    end
    return v;
  endfunction

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    item_t it;
    if (grant_o || deny_o || bus_err_o) begin
      if (sb.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R11 unexpected response: actual %b%b%b expected none", grant_o, deny_o, bus_err_o);
      end else begin
        it = sb.pop_front();
        chk(it.tag, "grant",   32'(grant_o),   32'(it.v.g));
        chk(it.tag, "deny",    32'(deny_o),    32'(it.v.d));
        chk(it.tag, "bus_err", 32'(bus_err_o), 32'(it.v.b));
        chk(it.tag, "wperr",   32'(wperr_o),   32'(it.flag));
      end
    end else if (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      n_chk++; n_err++;
      $display("FAIL %s missing response: actual none expected %b%b", it.tag, it.v.g, it.v.d);
    end
  end

  task automatic send(logic [1:0] op, logic obyte, logic [ADDR_W-1:0] addr, string tag, bit clr = 0);
    item_t it;
    @(posedge clk); #2;
    req_valid_i = 1; req_op_i = op; req_obyte_i = obyte; req_addr_i = addr; wperr_clr_i = clr;
    it.v = model(op, obyte, addr);
    if (op == 2'b10 && obyte) m_wpoff = 1;
    if (it.v.f) m_flag = 1; else if (clr) m_flag = 0;
    it.flag = m_flag; it.tag = tag; it.due = cyc + 1;
    sb.push_back(it);
    @(posedge clk); #2;
    req_valid_i = 0; wperr_clr_i = 0;
  endtask

  task automatic clear_flag(string tag);
    @(posedge clk); #2; wperr_clr_i = 1; m_flag = 0;
    @(posedge clk); #2; wperr_clr_i = 0;
    chk(tag, "wperr after clear", 32'(wperr_o), 32'd0);
  endtask

  task automatic do_reset(logic [15:0] sec, logic [WP_W-1:0] wp, bit por, int exp_me, string tag);
    @(posedge clk); #2;
    rst_n = 0; if (por) por_n = 0;
    opt_sec_i = sec; opt_wp_i = wp;
    m_sec = sec; m_wp = wp; m_wpoff = 0; m_flag = 0;
    repeat (3) @(posedge clk); #2;
    chk("R12", "outputs in reset", {26'd0, grant_o, deny_o, bus_err_o, wperr_o, err_irq_o, mass_erase_o}, 32'd0);
    me_cnt = 0;
    rst_n = 1; por_n = 1;
    repeat (8) @(posedge clk); #2;
    chk(tag, "mass erase pulses", 32'(me_cnt), 32'(exp_me));
  endtask

  localparam logic [ADDR_W-1:0] A_R0  = 17'h00400;
  localparam logic [ADDR_W-1:0] A_R3  = 17'h03000;
  localparam logic [ADDR_W-1:0] A_R5  = 17'h05000;
  localparam logic [ADDR_W-1:0] A_R9  = 17'h09010;
  localparam logic [ADDR_W-1:0] A_R15 = 17'h0F800;

  bit finished = 0;

  initial begin
    rst_n = 0; por_n = 0; opt_wp_i = '1; opt_sec_i = 16'h5AA5;
    dbg_mode_i = 0; boot_sel_i = 2'b00; req_valid_i = 0; req_op_i = 0;
    req_obyte_i = 0; req_addr_i = '0; err_ie_i = 0; wperr_clr_i = 0;
    m_wp = '1; m_sec = 16'h5AA5; m_wpoff = 0; m_flag = 0;

    // first power-up, unprotected, regions 8..15 guarded
    do_reset(16'h5AA5, 32'hFFFF_00FF, 1, 0, "R10 first capture");
    send(2'b01, 0, A_R3, "R5 program open region");
    send(2'b01, 0, A_R9, "R1 program guarded region");
    chk("R3", "irq with enable off", 32'(err_irq_o), 32'd0);
    err_ie_i = 1; #3;
    chk("R3", "irq with enable on", 32'(err_irq_o), 32'd1);
    clear_flag("R2 clear");
    chk("R3", "irq after clear", 32'(err_irq_o), 32'd0);
    send(2'b10, 0, A_R15, "R2 set beats clear", 1);
    chk("R2", "flag after set+clear", 32'(wperr_o), 32'd1);
    clear_flag("R2 clear again");
    dbg_mode_i = 1;
    send(2'b00, 0, A_R0, "R5 read in debug unprotected");
    send(2'b01, 0, A_R0, "R5 program region0 unprotected");
    dbg_mode_i = 0;
    opt_wp_i = '0; opt_sec_i = 16'h1111;
    send(2'b01, 0, A_R3, "R9 live option change ignored");
    send(2'b11, 0, A_R3, "R11 reserved op");
    chk("R11", "flag after reserved op", 32'(wperr_o), 32'd0);
    send(2'b10, 1, A_R0, "R8 option erase");
    send(2'b01, 0, A_R9, "R4 guard lifted");

    // system reset to protected level
    do_reset(16'h1234, 32'hFFFF_00FF, 0, 0, "R10 open to protected");
    send(2'b01, 0, A_R9, "R4 guard back after reset");
    clear_flag("R2 clear protected");
    send(2'b00, 0, A_R0, "R7 user read protected");
    send(2'b01, 0, A_R0, "R6 boot area program");
    clear_flag("R2 clear boot");
    send(2'b10, 0, A_R0 + 17'h00BFF, "R6 boot area top erase");
    clear_flag("R2 clear boot top");
    send(2'b01, 0, A_R5, "R6 region1+ allowed");
    dbg_mode_i = 1;
    send(2'b00, 0, A_R5, "R7 debug read bus error");
    chk("R7", "flag after refused read", 32'(wperr_o), 32'd0);
    send(2'b01, 0, A_R5, "R7 debug program");
    send(2'b01, 1, A_R0, "R8 option program in debug");
    send(2'b00, 1, A_R0, "R8 option read in debug");
    dbg_mode_i = 0; boot_sel_i = 2'b01;
    send(2'b00, 0, A_R3, "R7 sram boot read");
    boot_sel_i = 2'b10;
    send(2'b10, 0, A_R3, "R7 loader boot erase");
    boot_sel_i = 2'b00;

    // back to unprotected: mass erase once; then unchanged level: none
    do_reset(16'h5AA5, 32'hFFFF_FFFF, 0, 1, "R10 protected to open");
    do_reset(16'h5AA5, 32'hFFFF_FFFF, 0, 0, "R10 open to open");
    send(2'b01, 0, A_R0, "R5 after mass erase");

    repeat (4) @(posedge clk); #2;
    chk("R11", "scoreboard drained", 32'(sb.size()), 32'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule